// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block sits between a functional memory port and a small single-port SRAM of 32 words by 8 bits. It passes the functional address, write data, write strobe and read strobe straight through to the memory while idle. When a test request arrives, it takes over the memory port and runs a March test, one address at a time. For each element it produces the address sequence, the write words and the expected read words. It compares every read against the expected word and reports completion and a pass/fail flag.

Two algorithms are available. The short one has nine elements and the long one has six. A select input picks the algorithm at the moment the test is launched. A "0" or "1" in an operation means an all-zeros or all-ones word. The test stops at the first miscompare, and the port is handed back to the functional side as soon as the test ends.

Top module: `mbist_march_ctrl`

## Requirements
- R1: While no test is running, mem_addr, mem_wdata, mem_we and mem_re equal func_addr, func_wdata, func_we and func_re in the same cycle.
- R2: A test starts on a low-to-high transition of test_req seen while no test is running. alg_sel is captured at that edge. Further test_req edges, alg_sel changes and functional inputs have no effect on the memory port until the test ends.
- R3: With alg_sel=0 the elements run in this order: w0 ascending; r0,w1 ascending; r1 ascending; r1,w0 ascending; r0 ascending; r0,w1 descending; r1 descending; r1,w0 descending; r0 descending.
- R4: With alg_sel=1 the elements run in this order: w0 ascending; r0,w1,r1,w1,r1 descending; r1,w0,r0,w0,r0 descending; r0,w1,r1,w1,r1 ascending; r1,w0,r0,w0,r0 ascending; r0 ascending.
- R5: Every test write drives mem_wdata to 8'h00 for a "0" operation and 8'hFF for a "1" operation.
- R6: All operations of an element are applied to one address before the address moves. Ascending means 0 to 31 and descending means 31 to 0. The next element starts only after the last address of the current one.
- R7: The memory returns read data one cycle after mem_re. In the cycle after a test read, the controller issues no write and no read, and compares mem_rdata with the expected word.
- R8: On a fault-free memory the test ends with test_done=1 and test_fail=0.
- R9: On the first read whose data differs from the expected word, test_fail and test_done both go high on the same clock edge. No further memory operation is issued.
- R10: test_done and test_fail hold their values until the next accepted start, which clears both.
- R11: After reset, test_done=0, test_fail=0 and the port is in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_req | input | 1 | Test request; a rising edge launches a test |
| alg_sel | input | 1 | 0 = nine-element algorithm, 1 = six-element algorithm |
| func_addr | input | ADDR_W | Functional address |
| func_wdata | input | DATA_W | Functional write data |
| func_we | input | 1 | Functional write strobe |
| func_re | input | 1 | Functional read strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after mem_re |
| test_done | output | 1 | Test finished, held |
| test_fail | output | 1 | Miscompare seen, held |

## Verification
The bench builds the controller with its default parameters: a 5-bit address, 8-bit words and 32 words. At this size both ends of the address range are reached in each direction, and a stuck bit can be placed at bit 0 or bit 7 of word 0 or word 31. The bench builds its own list of the memory operations each algorithm should issue. It replays that list against a faulty-memory model to predict the exact operation on which the test should stop. Random stuck-bit faults, random functional traffic and mid-test toggling of test_req and alg_sel run alongside directed cases at the address extremes.

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int WORDS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_req,
  input  logic              alg_sel,
  input  logic [ADDR_W-1:0] func_addr,
  input  logic [DATA_W-1:0] func_wdata,
  input  logic              func_we,
  input  logic              func_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              test_done,
  output logic              test_fail
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(WORDS - 1);
  localparam int EL_W = 4;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CHECK} st_t;

  st_t               state;
  logic              alg_q, req_q, done_q, fail_q;
  logic [EL_W-1:0]   elem;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] exp_q;

  function automatic logic el_desc(input logic alg, input logic [EL_W-1:0] e);
    return alg ? (e == 1 || e == 2) : (e >= 5);
  endfunction

  function automatic logic el_seed(input logic alg, input logic [EL_W-1:0] e);
    return alg ? (e == 2 || e == 4) : (e == 2 || e == 3 || e == 6 || e == 7);
  endfunction

  function automatic logic [OP_W-1:0] op_last(input logic alg, input logic [EL_W-1:0] e);
    if (alg) return (e == 0 || e == 5) ? OP_W'(0) : OP_W'(4);
    return (e == 1 || e == 3 || e == 5 || e == 7) ? OP_W'(1) : OP_W'(0);
  endfunction

  logic busy, start, cur_rd, cur_val, dir, last_op, at_end, last_el, miss, adv;

  assign busy    = (state != S_IDLE);
  assign start   = test_req & ~req_q & ~busy;
  assign cur_rd  = (elem != '0) & ~op[0];
  assign cur_val = (op == '0) ? el_seed(alg_q, elem) : ~el_seed(alg_q, elem);
  assign dir     = el_desc(alg_q, elem);
  assign last_op = (op == op_last(alg_q, elem));
  assign at_end  = dir ? (addr == '0) : (addr == LAST_A);
  assign last_el = (elem == (alg_q ? EL_W'(5) : EL_W'(8)));
  assign miss    = (state == S_CHECK) && (mem_rdata != exp_q);
  assign adv     = ((state == S_ISSUE) && !cur_rd) || ((state == S_CHECK) && !miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      alg_q  <= 1'b0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      elem   <= '0;
      op     <= '0;
      addr   <= '0;
      exp_q  <= '0;
    end else begin
      req_q <= test_req;
      if (start) begin
        alg_q  <= alg_sel;
        elem   <= '0;
        op     <= '0;
        addr   <= '0;
        done_q <= 1'b0;
        fail_q <= 1'b0;
        state  <= S_ISSUE;
      end else if (miss) begin
        fail_q <= 1'b1;
        done_q <= 1'b1;
        state  <= S_IDLE;
      end else if (state == S_ISSUE && cur_rd) begin
        exp_q <= {DATA_W{cur_val}};
        state <= S_CHECK;
      end else if (adv) begin
        state <= S_ISSUE;
        if (!last_op) begin
          op <= op + 1'b1;
        end else begin
          op <= '0;
          if (!at_end) begin
            addr <= dir ? addr - 1'b1 : addr + 1'b1;
          end else if (!last_el) begin
            elem <= elem + 1'b1;
            addr <= el_desc(alg_q, elem + 1'b1) ? LAST_A : '0;
          end else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
      end
    end
  end

  assign mem_addr  = busy ? addr : func_addr;
  assign mem_wdata = busy ? {DATA_W{cur_val}} : func_wdata;
  assign mem_we    = busy ? (state == S_ISSUE && !cur_rd) : func_we;
  assign mem_re    = busy ? (state == S_ISSUE && cur_rd) : func_re;
  assign test_done = done_q;
  assign test_fail = fail_q;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic              test_done,
  input logic              test_fail,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_wdata
);
  a_r9_fail_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail |-> test_done);

  a_r9_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_fail) |-> $rose(test_done));

  a_r7_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_re) |=> (!mem_we && !mem_re));

  a_r5_word_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));

  a_r10_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && !start) |=> test_done);

  a_r2_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> test_done);
endmodule

bind mbist_march_ctrl mbist_march_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
  .test_done(test_done), .test_fail(test_fail),
  .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata)
);

// File: tb/mbist_march_ctrl_tb.sv
`timescale 1ns/1ps
module mbist_march_ctrl_tb_top;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NW = 32;
  localparam int MAXOPS = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic test_req = 1'b0, alg_sel = 1'b0;
  logic [AW-1:0] func_addr = '0;
  logic [DW-1:0] func_wdata = '0;
  logic func_we = 1'b0, func_re = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re, test_done, test_fail;

  always #2.5 clk = ~clk;

  mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_req(test_req), .alg_sel(alg_sel),
    .func_addr(func_addr), .func_wdata(func_wdata), .func_we(func_we), .func_re(func_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .test_done(test_done), .test_fail(test_fail));

  logic [DW-1:0] mem [NW];
  bit f_en = 0; int f_addr = 0; int f_bit = 0; bit f_val = 0;

  function automatic logic [DW-1:0] faulty(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= faulty(int'(mem_addr), mem_wdata);
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  bit ex_rd [MAXOPS];
  int ex_addr [MAXOPS];
  bit ex_val [MAXOPS];
  int n_ops;

  task automatic add_el(input bit dn, input string s);
    for (int a = 0; a < NW; a++) begin
      for (int k = 0; k < s.len(); k += 2) begin
        ex_rd[n_ops]   = (s.getc(k) == "r");
        ex_val[n_ops]  = (s.getc(k+1) == "1");
        ex_addr[n_ops] = dn ? NW-1-a : a;
        n_ops++;
      end
    end
  endtask

  task automatic build(input bit alg);
    n_ops = 0;
    if (!alg) begin
      add_el(0,"w0"); add_el(0,"r0w1"); add_el(0,"r1"); add_el(0,"r1w0"); add_el(0,"r0");
      add_el(1,"r0w1"); add_el(1,"r1"); add_el(1,"r1w0"); add_el(1,"r0");
    end else begin
      add_el(0,"w0"); add_el(1,"r0w1r1w1r1"); add_el(1,"r1w0r0w0r0");
      add_el(0,"r0w1r1w1r1"); add_el(0,"r1w0r0w0r0"); add_el(0,"r0");
    end
  endtask

  function automatic int predict_stop();
    logic [DW-1:0] sh [NW];
    for (int i = 0; i < n_ops; i++) begin
      if (ex_rd[i]) begin
        if (sh[ex_addr[i]] !== {DW{ex_val[i]}}) return i;
      end else sh[ex_addr[i]] = faulty(ex_addr[i], {DW{ex_val[i]}});
    end
    return -1;
  endfunction

  task automatic run_test(input bit alg, input bit fe, input int fa, input int fb, input bit fv);
    int stop, exp_cnt, obs, seq_err, r7_err, cyc;
    bit prev_rd, seen;
    string rq;
    f_en = fe; f_addr = fa; f_bit = fb; f_val = fv;
    build(alg);
    stop = predict_stop();
    exp_cnt = (stop < 0) ? n_ops : stop + 1;
    rq = alg ? "R4" : "R3";
    obs = 0; seq_err = 0; r7_err = 0; prev_rd = 0; seen = 0;
    @(negedge clk);
    func_we = 0; func_re = 0; test_req = 0; alg_sel = alg;
    @(negedge clk);
    test_req = 1;
    for (cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (test_done) begin seen = 1; break; end
      if (mem_we || mem_re) begin
        if (prev_rd) r7_err++;
        if (obs >= n_ops || mem_re != ex_rd[obs] || int'(mem_addr) != ex_addr[obs] ||
            (mem_we && mem_wdata != {DW{ex_val[obs]}})) begin
          if (seq_err == 0)
            $display("  op %0d: re=%0b addr=%0d wd=%0h", obs, mem_re, mem_addr, mem_wdata);
          seq_err++;
        end
        obs++;
      end
      prev_rd = mem_re;
      func_we = 1'($urandom); func_re = 1'($urandom);
      func_addr = AW'($urandom); func_wdata = DW'($urandom);
      alg_sel = 1'($urandom);
      if (cyc == 40) test_req = 0;
      if (cyc == 42) test_req = 1;
    end
    func_we = 0; func_re = 0;
    chk(seen, "R8", "test_done reached", seen, 1);
    chk(test_fail == (stop >= 0), fe ? "R9" : "R8", "test_fail", test_fail, stop >= 0);
    chk(obs == exp_cnt, fe ? "R9" : "R6", "operation count", obs, exp_cnt);
    chk(seq_err == 0, rq, "operation order/pattern (R5 R6)", seq_err, 0);
    chk(r7_err == 0, "R7", "op right after read", r7_err, 0);
  endtask

  task automatic passthru_chk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      func_we = 1'($urandom); func_re = 1'($urandom);
      func_addr = AW'($urandom); func_wdata = DW'($urandom);
      #1;
      chk(mem_we == func_we && mem_re == func_re && mem_addr == func_addr &&
          mem_wdata == func_wdata, "R1", "pass-through",
          {mem_we, mem_re, mem_addr, mem_wdata}, {func_we, func_re, func_addr, func_wdata});
    end
    @(negedge clk); func_we = 0; func_re = 0;
  endtask

  task automatic hold_chk();
    bit d = test_done, f = test_fail;
    repeat (20) @(negedge clk);
    chk(test_done == d && test_fail == f, "R10", "flags held (R2 no restart on high req)",
        {test_done, test_fail}, {d, f});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(test_done == 0 && test_fail == 0, "R11", "reset flags", {test_done, test_fail}, 0);
    rst_n = 1;
    passthru_chk(4);

    run_test(0, 0, 0, 0, 0); hold_chk();
    run_test(1, 0, 0, 0, 0); hold_chk();
    run_test(0, 1, 0, 0, 1); hold_chk();
    @(negedge clk); test_req = 0;
    @(negedge clk); test_req = 1;
    @(negedge clk);
    chk(test_done == 0 && test_fail == 0, "R10", "start clears flags",
        {test_done, test_fail}, 0);
    repeat (2000) @(negedge clk);
    run_test(1, 1, 31, 7, 0); hold_chk();
    run_test(0, 1, 31, 3, 0);
    run_test(1, 1, 0, 0, 1);
    for (int t = 0; t < 8; t++)
      run_test(1'($urandom), 1'($urandom), int'($urandom_range(NW-1)),
               int'($urandom_range(DW-1)), 1'($urandom));
    passthru_chk(8);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule